// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

The block pairs a small direct-mapped line store with a fully associative victim buffer of a few entries. Every lookup probes both structures in the same cycle. Lines only reach the victim buffer by being pushed out of the direct-mapped store, either when a refill overwrites their set or when a swap replaces them. A hit in the direct-mapped store returns data at once. A hit in the victim buffer also returns data at once, and then spends one stall cycle exchanging that line with the line sitting in its set. After that, the requested line lives in the direct-mapped store and the displaced line occupies the victim entry that was just emptied.

A lookup that misses both structures is not completed. The block asks the next level for the line, installs the refilled line, and pushes any valid line it replaces into the victim buffer. The requester keeps presenting the same request until it sees a hit, and the retried lookup then hits. When the victim buffer is full, its least-recently-used entry makes room. If that entry is dirty, it leaves through a write-back output with a valid/ready handshake. Addresses are line addresses with one data word per line. The low `IDX_W` bits select the direct-mapped set.

Control is a four-state machine. `ST_LOOK` accepts lookups. `ST_SWAP` performs the exchange. `ST_FILL` waits for the refill. `ST_DRAIN` holds a dirty line until the write-back is accepted. The transitions are:

- `ST_LOOK` to `ST_SWAP` on a victim-only hit.
- `ST_LOOK` to `ST_FILL` on a double miss.
- `ST_SWAP` to `ST_LOOK` unconditionally.
- `ST_FILL` to `ST_LOOK` on a refill that drops nothing dirty.
- `ST_FILL` to `ST_DRAIN` on a refill that drops a dirty line.
- `ST_DRAIN` to `ST_LOOK` when the write-back is accepted.

Top module: `vc_cache_top`

## Requirements
- R1: A line address is resident in at most one place: never in both the direct-mapped store and the victim buffer, and never in two victim entries at once.
- R2: While `ready` is 1 and `req_valid` is 1, a direct-mapped hit drives `hit`=1 and `rdata` in the same cycle. A write hit (`req_write`=1) replaces the line data with `req_wdata` and marks it dirty, starting with the next cycle.
- R3: A victim-only hit drives `hit`=1 and the victim line's data in the same cycle. It is followed by exactly one cycle with `ready`=0, after which the line is in the direct-mapped store. The line that was displaced from the store sits in the victim entry that supplied the hit. A write applied this way stores `req_wdata` and marks the line dirty.
- R4: A miss in both structures drives `hit`=0. From the next cycle on, `refill_req`=1 with `refill_addr` equal to the missed address, held stable with `ready`=0 until a cycle with `refill_valid`=1.
- R5: On `refill_valid`=1, `refill_data` is installed clean in the set. A valid line it displaces goes into an empty victim entry if one exists, and otherwise into the least-recently-used entry.
- R6: Victim recency is updated whenever an entry is written, either by insertion or by swap. The entry pushed out of a full buffer is always the one written longest ago.
- R7: A dirty line pushed out of the victim buffer appears on `wb_valid`/`wb_addr`/`wb_data` one cycle after the refill. It is held stable with `ready`=0 until `wb_ready`=1. A clean line pushed out is dropped without a write-back.
- R8: A single victim entry (`VC_N`=1) behaves by the same rules as larger buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Line address of the request |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Block accepts lookups this cycle |
| hit | output | 1 | Request completed this cycle |
| rdata | output | DATA_W | Read data, valid with `hit` |
| refill_req | output | 1 | Refill request to the next level |
| refill_addr | output | ADDR_W | Line address to refill |
| refill_valid | input | 1 | Refill data present |
| refill_data | input | DATA_W | Refill data |
| wb_valid | output | 1 | Dirty line offered for write-back |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | ADDR_W | Line address being written back |
| wb_data | output | DATA_W | Line data being written back |

## Verification
`hit` and `rdata` are combinational and due in the lookup cycle itself. The `ready` drop of a swap is due one cycle after the victim hit. `refill_req` is due one cycle after a double miss. `wb_valid` is due one cycle after the refill that drops a dirty line. A behavioural model advances its state on each rising edge and predicts these outputs, and every output is compared against it at the falling edge of the same cycle. The model's refill responder answers on the third `ST_FILL` cycle, and its write-back acceptor holds off for one cycle, so every stall path is observed for more than one cycle.

// File: rtl/vc_cache_pkg.sv
package vc_cache_pkg;
    typedef enum logic [1:0] {
        ST_LOOK  = 2'd0,
        ST_SWAP  = 2'd1,
        ST_FILL  = 2'd2,
        ST_DRAIN = 2'd3
    } vc_state_e;

    // width of an entry index; a single entry still needs one bit
    function automatic int vc_sel_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vc_dm_array.sv
module vc_dm_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int SETS  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [ADDR_W-1:0] line_addr,
    output logic [DATA_W-1:0] line_data,
    input  logic              wen,
    input  logic              wdirty,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata
);
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    assign rd_idx     = look_addr[IDX_W-1:0];
    assign wr_idx     = waddr[IDX_W-1:0];
    assign line_valid = valid_q[rd_idx];
    assign line_dirty = dirty_q[rd_idx];
    assign line_addr  = {tag_q[rd_idx], rd_idx};
    assign line_data  = data_q[rd_idx];
    assign hit        = valid_q[rd_idx] && (tag_q[rd_idx] == look_addr[ADDR_W-1:IDX_W]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wen) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wdirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wen) begin
            tag_q[wr_idx]  <= waddr[ADDR_W-1:IDX_W];
            data_q[wr_idx] <= wdata;
        end
    end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf
    import vc_cache_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int VC_N   = 4,
    localparam int SEL_W = vc_sel_w(VC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    output logic [VC_N-1:0]   hit_vec,
    output logic              hit,
    output logic [SEL_W-1:0]  hit_idx,
    output logic [DATA_W-1:0] hit_data,
    output logic              hit_dirty,
    output logic [SEL_W-1:0]  alloc_idx,
    output logic              alloc_valid,
    output logic              alloc_dirty,
    output logic [ADDR_W-1:0] alloc_addr,
    output logic [DATA_W-1:0] alloc_data,
    input  logic              wen,
    input  logic [SEL_W-1:0]  widx,
    input  logic              wvalid,
    input  logic              wdirty,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata
);
    logic [VC_N-1:0]   valid_q;
    logic [VC_N-1:0]   dirty_q;
    logic [ADDR_W-1:0] addr_q [VC_N];
    logic [DATA_W-1:0] data_q [VC_N];
    logic [SEL_W-1:0]  age_q  [VC_N];   // 0 = most recent, VC_N-1 = oldest

    for (genvar g = 0; g < VC_N; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (addr_q[g] == look_addr);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < VC_N; i++) begin
            if (hit_vec[i]) hit_idx = SEL_W'(i);
        end
    end

    assign hit_data  = data_q[hit_idx];
    assign hit_dirty = dirty_q[hit_idx];

    // empty entry first (lowest index), otherwise the oldest one
    always_comb begin
        logic found;
        found     = 1'b0;
        alloc_idx = '0;
        for (int i = 0; i < VC_N; i++) begin
            if (!found && !valid_q[i]) begin
                alloc_idx = SEL_W'(i);
                found     = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < VC_N; i++) begin
                if (age_q[i] == SEL_W'(VC_N - 1)) alloc_idx = SEL_W'(i);
            end
        end
    end

    assign alloc_valid = valid_q[alloc_idx];
    assign alloc_dirty = dirty_q[alloc_idx];
    assign alloc_addr  = addr_q[alloc_idx];
    assign alloc_data  = data_q[alloc_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < VC_N; i++) age_q[i] <= SEL_W'(i);
        end else if (wen) begin
            valid_q[widx] <= wvalid;
            dirty_q[widx] <= wdirty;
            for (int i = 0; i < VC_N; i++) begin
                if (SEL_W'(i) == widx)          age_q[i] <= '0;
                else if (age_q[i] < age_q[widx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wen) begin
            addr_q[widx] <= waddr;
            data_q[widx] <= wdata;
        end
    end
endmodule

// File: rtl/vc_cache_top.sv
module vc_cache_top
    import vc_cache_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int VC_N   = 4,
    localparam int SEL_W = vc_sel_w(VC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              hit,
    output logic [DATA_W-1:0] rdata,
    output logic              refill_req,
    output logic [ADDR_W-1:0] refill_addr,
    input  logic              refill_valid,
    input  logic [DATA_W-1:0] refill_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    vc_state_e state_q, state_d;

    logic [ADDR_W-1:0] lat_addr_q;
    logic              lat_write_q;
    logic [DATA_W-1:0] lat_wdata_q;
    logic [ADDR_W-1:0] wb_addr_q;
    logic [DATA_W-1:0] wb_data_q;

    logic [ADDR_W-1:0] look_addr;
    logic              m_hit, m_valid, m_dirty;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_data;
    logic              m_wen, m_wdirty;
    logic [ADDR_W-1:0] m_waddr;
    logic [DATA_W-1:0] m_wdata;

    logic [VC_N-1:0]   v_hit_vec;
    logic              v_hit, v_hit_dirty;
    logic [SEL_W-1:0]  v_hit_idx, v_alloc_idx;
    logic [DATA_W-1:0] v_hit_data, v_alloc_data;
    logic              v_alloc_valid, v_alloc_dirty;
    logic [ADDR_W-1:0] v_alloc_addr;
    logic              v_wen;
    logic [SEL_W-1:0]  v_widx;

    logic in_look, fill_now, drop_dirty;

    assign in_look    = (state_q == ST_LOOK);
    assign look_addr  = in_look ? req_addr : lat_addr_q;
    assign fill_now   = (state_q == ST_FILL) && refill_valid;
    assign drop_dirty = fill_now && m_valid && v_alloc_valid && v_alloc_dirty;

    vc_dm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dm_i (
        .clk(clk), .rst_n(rst_n), .look_addr(look_addr),
        .hit(m_hit), .line_valid(m_valid), .line_dirty(m_dirty),
        .line_addr(m_addr), .line_data(m_data),
        .wen(m_wen), .wdirty(m_wdirty), .waddr(m_waddr), .wdata(m_wdata)
    );

    vc_victim_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VC_N(VC_N)) vb_i (
        .clk(clk), .rst_n(rst_n), .look_addr(look_addr),
        .hit_vec(v_hit_vec), .hit(v_hit), .hit_idx(v_hit_idx),
        .hit_data(v_hit_data), .hit_dirty(v_hit_dirty),
        .alloc_idx(v_alloc_idx), .alloc_valid(v_alloc_valid), .alloc_dirty(v_alloc_dirty),
        .alloc_addr(v_alloc_addr), .alloc_data(v_alloc_data),
        .wen(v_wen), .widx(v_widx), .wvalid(m_valid), .wdirty(m_dirty),
        .waddr(m_addr), .wdata(m_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOOK;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOK:  if (req_valid && !m_hit) state_d = v_hit ? ST_SWAP : ST_FILL;
            ST_SWAP:  state_d = ST_LOOK;
            ST_FILL:  if (refill_valid) state_d = drop_dirty ? ST_DRAIN : ST_LOOK;
            ST_DRAIN: if (wb_ready) state_d = ST_LOOK;
        endcase
    end

    // request and write-back holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr_q  <= '0;
            lat_write_q <= 1'b0;
            lat_wdata_q <= '0;
            wb_addr_q   <= '0;
            wb_data_q   <= '0;
        end else begin
            if (in_look && req_valid && !m_hit) begin
                lat_addr_q  <= req_addr;
                lat_write_q <= req_write;
                lat_wdata_q <= req_wdata;
            end
            if (drop_dirty) begin
                wb_addr_q <= v_alloc_addr;
                wb_data_q <= v_alloc_data;
            end
        end
    end

    // outputs and array write controls
    always_comb begin
        ready       = in_look;
        hit         = in_look && req_valid && (m_hit || v_hit);
        rdata       = m_hit ? m_data : v_hit_data;
        refill_req  = (state_q == ST_FILL);
        refill_addr = lat_addr_q;
        wb_valid    = (state_q == ST_DRAIN);
        wb_addr     = wb_addr_q;
        wb_data     = wb_data_q;

        m_wen    = 1'b0;
        m_waddr  = lat_addr_q;
        m_wdata  = refill_data;
        m_wdirty = 1'b0;
        v_wen    = 1'b0;
        v_widx   = v_hit_idx;

        unique case (state_q)
            ST_LOOK: begin
                if (req_valid && m_hit && req_write) begin
                    m_wen    = 1'b1;
                    m_waddr  = req_addr;
                    m_wdata  = req_wdata;
                    m_wdirty = 1'b1;
                end
            end
            ST_SWAP: begin
                m_wen    = 1'b1;
                m_wdata  = lat_write_q ? lat_wdata_q : v_hit_data;
                m_wdirty = lat_write_q || v_hit_dirty;
                v_wen    = 1'b1;
            end
            ST_FILL: begin
                m_wen  = refill_valid;
                v_wen  = refill_valid && m_valid;
                v_widx = v_alloc_idx;
            end
            ST_DRAIN: ;
        endcase
    end
endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int VC_N   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              hit,
    input logic              m_hit,
    input logic              v_hit,
    input logic [VC_N-1:0]   v_hit_vec,
    input logic              refill_req,
    input logic              refill_valid,
    input logic [ADDR_W-1:0] refill_addr,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data
);
    AST_SINGLE_HOME: assert property (@(posedge clk) disable iff (!rst_n) !(m_hit && v_hit)); // R1
    AST_VICTIM_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(v_hit_vec)); // R1
    AST_HIT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n) hit |-> ready); // R2
    AST_SWAP_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n) (hit && !m_hit) |=> !ready ##1 ready); // R3
    AST_REFILL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr))); // R4
    AST_REFILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n) refill_req |-> !ready); // R4
    AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n) (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data))); // R7
    AST_WB_STALLS: assert property (@(posedge clk) disable iff (!rst_n) wb_valid |-> !ready); // R7
endmodule

bind vc_cache_top vc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VC_N(VC_N)) chk_i (
    .clk(clk), .rst_n(rst_n), .ready(ready), .hit(hit), .m_hit(m_hit), .v_hit(v_hit),
    .v_hit_vec(v_hit_vec), .refill_req(refill_req), .refill_valid(refill_valid),
    .refill_addr(refill_addr), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/vc_cache_top_tb_top.sv
module vc_cache_tb_lane #(
    parameter int VC_N = 4
) (
    input logic clk,
    input logic rst_n
);
    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 3;
    localparam int SETS   = 1 << IDX_W;

    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              refill_valid = 1'b0;
    logic [DATA_W-1:0] refill_data  = '0;
    logic              wb_ready = 1'b0;
    logic              ready, hit, refill_req, wb_valid;
    logic [DATA_W-1:0] rdata, wb_data;
    logic [ADDR_W-1:0] refill_addr, wb_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    vc_cache_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .VC_N(VC_N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .hit(hit), .rdata(rdata),
        .refill_req(refill_req), .refill_addr(refill_addr),
        .refill_valid(refill_valid), .refill_data(refill_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    // behavioural model: set arrays plus a recency queue (front = newest)
    int mv [SETS];
    int mt [SETS];
    int md [SETS];
    int my [SETS];
    int qa [$];
    int qd [$];
    int qy [$];
    int st = 0;   // 0 lookup, 1 exchange, 2 refill wait, 3 write-back wait
    int s_addr, s_wr, s_wd, s_j, fcnt, wcnt, wba, wbd;

    function automatic int fill_val(input int a);
        return (a * 37 + 5) & 16'hFFFF;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s%s: actual %0d expected %0d at %0t", tag,
                     (VC_N == 1) ? " R8 single entry" : "", act, exp, $time);
        end
    endtask

    task automatic step(output bit got);
        int idx, vj, e_rd;
        bit mh, e_hit;
        @(negedge clk);
        mh = 1'b0; vj = -1; e_hit = 1'b0; e_rd = 0;
        idx = int'(req_addr) % SETS;
        if (st == 0 && req_valid) begin
            mh = (mv[idx] != 0) && (mt[idx] == int'(req_addr) / SETS);
            foreach (qa[k]) if (qa[k] == int'(req_addr)) vj = k;
            if (mh)           begin e_hit = 1'b1; e_rd = md[idx]; end
            else if (vj >= 0) begin e_hit = 1'b1; e_rd = qd[vj]; end
        end
        chk("R3 ready", int'(ready), (st == 0) ? 1 : 0);
        chk("R2 hit", int'(hit), int'(e_hit));
        if (e_hit) chk("R5 rdata", int'(rdata), e_rd);
        chk("R4 refill_req", int'(refill_req), (st == 2) ? 1 : 0);
        if (st == 2) chk("R4 refill_addr", int'(refill_addr), s_addr);
        chk("R7 wb_valid", int'(wb_valid), (st == 3) ? 1 : 0);
        if (st == 3) begin
            chk("R6 wb_addr", int'(wb_addr), wba);
            chk("R7 wb_data", int'(wb_data), wbd);
        end
        got = e_hit;
        @(posedge clk);
        case (st)
            0: if (req_valid) begin
                if (mh) begin
                    if (req_write) begin md[idx] = int'(req_wdata); my[idx] = 1; end
                end else begin
                    s_addr = int'(req_addr); s_wr = int'(req_write); s_wd = int'(req_wdata);
                    if (vj >= 0) begin s_j = vj; st = 1; end
                    else begin fcnt = 0; st = 2; end
                end
            end
            1: begin
                int nd, ny;
                idx = s_addr % SETS;
                nd = qd[s_j]; ny = qy[s_j];
                qa.delete(s_j); qd.delete(s_j); qy.delete(s_j);
                if (mv[idx] != 0) begin
                    qa.push_front(mt[idx] * SETS + idx); qd.push_front(md[idx]); qy.push_front(my[idx]);
                end
                mv[idx] = 1; mt[idx] = s_addr / SETS;
                md[idx] = s_wr ? s_wd : nd;
                my[idx] = (s_wr != 0 || ny != 0) ? 1 : 0;
                st = 0;
            end
            2: if (refill_valid) begin
                idx = s_addr % SETS;
                st = 0;
                if (mv[idx] != 0) begin
                    qa.push_front(mt[idx] * SETS + idx); qd.push_front(md[idx]); qy.push_front(my[idx]);
                    if (qa.size() > VC_N) begin
                        int da, dd, dy;
                        da = qa.pop_back(); dd = qd.pop_back(); dy = qy.pop_back();
                        if (dy != 0) begin wba = da; wbd = dd; wcnt = 0; st = 3; end
                    end
                end
                mv[idx] = 1; mt[idx] = s_addr / SETS; md[idx] = fill_val(s_addr); my[idx] = 0;
            end else fcnt++;
            3: if (wb_ready) st = 0; else wcnt++;
            default: st = 0;
        endcase
        #1;
        refill_valid = (st == 2 && fcnt == 2);
        refill_data  = DATA_W'(fill_val(s_addr));
        wb_ready     = (st == 3 && wcnt >= 1);
    endtask

    task automatic access(input int a, input bit w, input int d);
        bit got;
        req_valid = 1'b1; req_addr = ADDR_W'(a); req_write = w; req_wdata = DATA_W'(d);
        do step(got); while (!got);
        req_valid = 1'b0;
    endtask

    initial begin
        int seq_a [16] = '{2, 10, 18, 26, 34, 2, 10, 42, 50, 58, 66, 74, 18, 5, 13, 5};
        bit seq_w [16] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0};
        logic [15:0] lfsr;
        bit dummy;
        for (int i = 0; i < SETS; i++) begin mv[i] = 0; mt[i] = 0; md[i] = 0; my[i] = 0; end
        s_addr = 0; s_wr = 0; s_wd = 0; s_j = 0; fcnt = 0; wcnt = 0; wba = 0; wbd = 0;
        @(posedge rst_n);
        @(posedge clk);
        #1;
        step(dummy);                          // reset state: idle, nothing pending
        // R1 R5 R6: one hot set, conflicting lines cycle through the buffer
        for (int i = 0; i < 16; i++) access(seq_a[i], seq_w[i], 16'hA000 + i);
        step(dummy);
        lfsr = 16'hACE1;
        for (int i = 0; i < 120; i++) begin
            int a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = int'(lfsr[4:2]) * SETS + int'(lfsr[1:0]);
            access(a, lfsr[5] & lfsr[7], int'(lfsr ^ 16'h5A5A));
            if (lfsr[8]) step(dummy);
        end
        step(dummy);
        done = 1'b1;
    end
endmodule

module vc_cache_top_tb_top;
    logic clk   = 1'b0;
    logic rst_n = 1'b0;

    always #2 clk = ~clk;

    vc_cache_tb_lane #(.VC_N(4)) lane_wide_i (.clk(clk), .rst_n(rst_n));
    vc_cache_tb_lane #(.VC_N(1)) lane_one_i  (.clk(clk), .rst_n(rst_n));

    initial begin
        int tot, bad;
        bit timed_out;
        timed_out = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        fork
            wait (lane_wide_i.done && lane_one_i.done);
            begin
                repeat (50000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        tot = lane_wide_i.n_chk + lane_one_i.n_chk;
        bad = lane_wide_i.n_fail + lane_one_i.n_fail;
        if (timed_out) begin
            tot++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", tot, bad);
        $finish;
    end
endmodule